// File: doc/BRIEF.md
# Banked Memory Pager

This block sits between an 8-bit CPU with a 64 KiB address space and a 1 MiB physical memory. Half of that memory is flash and half is SRAM. The CPU's logical space is cut into four 16 KiB windows. The two top address bits pick one of four page registers. The six-bit page value in that register supplies the upper physical address lines. The top bit of the page value picks the device: flash or SRAM.

Software programs the page registers and a global enable register with I/O write cycles. After reset, paging is off. While paging is off, every window shows the first 16 KiB of flash, so the CPU starts from a fixed boot image whatever the page registers hold.

The block drives the six upper physical address lines. It also drives one active-low chip select for each device, gated by the memory request strobe. The lower fourteen address lines go to both devices unchanged and are not routed through this block.

Top module: `memory_pager`

## Requirements
- R1: After reset, all four page registers hold 0 and paging is off. Any memory request then drives `physHi` = 0 and asserts `romCsN` low.
- R2: While paging is off, `physHi` is 0 and only `romCsN` can go low, whatever the page registers hold.
- R3: An accepted I/O write to port 0x78, 0x79, 0x7A or 0x7B loads `dataIn[5:0]` into the page register for window 0, 1, 2 or 3 respectively. `dataIn[7:6]` are ignored.
- R4: An accepted I/O write to port 0x7C sets the paging enable from `dataIn[0]`. Bits 7..1 are ignored.
- R5: An I/O write is accepted only when `iorqN` = 0, `m1N` = 1, `wrN` = 0 and `rdN` = 1, and `addr[7:0]` matches the port exactly. Any other cycle leaves every register unchanged.
- R6: While paging is on, `physHi` equals the page register selected by `addr[15:14]` (0x0000–0x3FFF uses window 0, up to 0xC000–0xFFFF for window 3).
- R7: With `mreqN` = 0, page bit 5 = 0 drives `romCsN` low and page bit 5 = 1 drives `ramCsN` low. With `mreqN` = 1 both selects are high, and the two are never low together.
- R8: Turning paging off and on again restores the earlier mapping, because the page registers keep their contents while paging is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU address bus |
| dataIn | input | 8 | CPU data bus (write data) |
| mreqN | input | 1 | Memory request, active low |
| iorqN | input | 1 | I/O request, active low |
| m1N | input | 1 | Opcode fetch / interrupt acknowledge, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| physHi | output | 6 | Physical address bits 19..14 |
| romCsN | output | 1 | Flash chip select, active low |
| ramCsN | output | 1 | SRAM chip select, active low |

## Verification
The assertions assume that the address and data buses are stable around the clock edge on which an I/O write is taken. They also assume that `mreqN` and `iorqN` are never low together, as on the real CPU. The bench changes inputs only on the falling clock edge, and it never asserts a memory request and an I/O request in the same cycle. Its random strobe combinations include rejected I/O cycles: M1 low, read low, or a near-miss port number. It then reads the mapping back to confirm that nothing changed.

// File: rtl/pager_pkg.sv
package pager_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int PAGE_W    = 6;
  localparam int BANK_BITS = 2;
  localparam int BANKS     = 1 << BANK_BITS;
  localparam int OFFSET_W  = ADDR_W - BANK_BITS;
  localparam int PORT_W    = 8;

  typedef struct packed {
    logic                 pageWr;
    logic [BANK_BITS-1:0] pageIdx;
    logic                 enableWr;
  } pagerStrobes_t;
endpackage

// File: rtl/pager_ctrl.sv
module pager_ctrl
  import pager_pkg::*;
#(
  parameter logic [PORT_W-1:0] PAGE_BASE   = 8'h78,
  parameter logic [PORT_W-1:0] ENABLE_PORT = 8'h7C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] portAddr,
  input  logic              iorqN,
  input  logic              m1N,
  input  logic              rdN,
  input  logic              wrN,
  output pagerStrobes_t     strobes
);
  logic ioWriteCycle;

  assign ioWriteCycle     = !iorqN && m1N && !wrN && rdN;
  assign strobes.pageWr   = ioWriteCycle &&
                            (portAddr[PORT_W-1:BANK_BITS] == PAGE_BASE[PORT_W-1:BANK_BITS]);
  assign strobes.pageIdx  = portAddr[BANK_BITS-1:0];
  assign strobes.enableWr = ioWriteCycle && (portAddr == ENABLE_PORT);

  // R5: strobes only during a qualified I/O write cycle
  assert_strobe_qualified_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pageWr || strobes.enableWr) |-> (!iorqN && m1N && !wrN && rdN));
  assert_single_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.pageWr, strobes.enableWr}));
endmodule

// File: rtl/pager_datapath.sv
module pager_datapath
  import pager_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pagerStrobes_t        strobes,
  input  logic [PAGE_W-1:0]    wrData,
  input  logic                 enBit,
  input  logic [BANK_BITS-1:0] bankSel,
  input  logic                 mreqN,
  output logic [PAGE_W-1:0]    physHi,
  output logic                 romCsN,
  output logic                 ramCsN
);
  logic [PAGE_W-1:0] pageReg [BANKS];
  logic              pagingOn;
  logic [PAGE_W-1:0] selPage;
  logic              devIsRam;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)
        pageReg[b] <= '0;
      else if (strobes.pageWr && strobes.pageIdx == BANK_BITS'(b))
        pageReg[b] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      pagingOn <= 1'b0;
    else if (strobes.enableWr)
      pagingOn <= enBit;
  end

  always_comb begin
    selPage  = pagingOn ? pageReg[bankSel] : '0;
    devIsRam = selPage[PAGE_W-1];
  end

  assign physHi = selPage;
  assign romCsN = !(!mreqN && !devIsRam);
  assign ramCsN = !(!mreqN && devIsRam);

  // R3: a page write lands in the addressed register
  assert_page_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pageWr |=> pageReg[$past(strobes.pageIdx)] == $past(wrData));
  // R4: enable follows the written bit
  assert_enable_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enableWr |=> pagingOn == $past(enBit));
  // R8: registers hold without a write strobe
  assert_page_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pageWr |=> $stable(pageReg[0]) && $stable(pageReg[BANKS-1]));
  // R2: disabled paging shows flash page 0
  assert_disabled_rom_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pagingOn |-> (physHi == '0) && ramCsN);
  // R7: selects never overlap and idle without a memory request
  assert_cs_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(!romCsN && !ramCsN));
  assert_cs_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    mreqN |-> (romCsN && ramCsN));
endmodule

// File: rtl/memory_pager.sv
module memory_pager
  import pager_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       addr,
  input  logic [7:0]        dataIn,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic              m1N,
  input  logic              rdN,
  input  logic              wrN,
  output logic [5:0]        physHi,
  output logic              romCsN,
  output logic              ramCsN
);
  pagerStrobes_t strobes;
  logic          unusedDataBits;

  assign unusedDataBits = ^dataIn[DATA_W-1:PAGE_W];

  pager_ctrl #(
    .PAGE_BASE   (8'h78),
    .ENABLE_PORT (8'h7C)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .portAddr (addr[PORT_W-1:0]),
    .iorqN    (iorqN),
    .m1N      (m1N),
    .rdN      (rdN),
    .wrN      (wrN),
    .strobes  (strobes)
  );

  pager_datapath i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (dataIn[PAGE_W-1:0]),
    .enBit   (dataIn[0]),
    .bankSel (addr[ADDR_W-1:OFFSET_W]),
    .mreqN   (mreqN),
    .physHi  (physHi),
    .romCsN  (romCsN),
    .ramCsN  (ramCsN)
  );
endmodule

// File: tb/test_memory_pager.sv
module test_memory_pager;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic        mreqN = 1'b1, iorqN = 1'b1, m1N = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [5:0]  physHi;
  logic        romCsN, ramCsN;

  int testsRun = 0;
  int testsFailed = 0;
  logic [5:0] expPage [4];
  logic       expOn;

  memory_pager i_memory_pager (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .mreqN(mreqN), .iorqN(iorqN), .m1N(m1N), .rdN(rdN), .wrN(wrN),
    .physHi(physHi), .romCsN(romCsN), .ramCsN(ramCsN)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] expMap(input logic [15:0] a, input logic mreq);
    logic [5:0] p;
    p = expOn ? expPage[a[15:14]] : 6'd0;
    return {p, !(mreq && !p[5]), !(mreq && p[5])};
  endfunction

  task automatic check(input string req, input logic [15:0] a, input logic mreq);
    logic [7:0] expv, act;
    @(negedge clk);
    addr = a; mreqN = !mreq; iorqN = 1'b1; wrN = 1'b1; rdN = !mreq;
    #2;
    expv = expMap(a, mreq);
    act  = {physHi, romCsN, ramCsN};
    testsRun++;
    if (act !== expv) begin
      testsFailed++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, act, expv);
    end
  endtask

  task automatic ioWrite(input logic [7:0] port, input logic [7:0] d,
                         input logic m1, input logic rd);
    logic ok;
    @(negedge clk);
    mreqN = 1'b1; addr = {8'h00, port}; dataIn = d;
    iorqN = 1'b0; wrN = 1'b0; m1N = m1; rdN = rd;
    @(negedge clk);
    iorqN = 1'b1; wrN = 1'b1; m1N = 1'b1; rdN = 1'b1;
    ok = m1 && rd;
    if (ok && port[7:2] == 6'b011110) expPage[port[1:0]] = d[5:0];
    if (ok && port == 8'h7C) expOn = d[0];
  endtask

  task automatic sweep(input string req);
    for (int b = 0; b < 4; b++) check(req, {b[1:0], 14'h1A5}, 1'b1);
  endtask

  initial begin
    #(10 * 200000);
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < 4; b++) expPage[b] = '0;
    expOn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    sweep("R1");
    check("R7 idle", 16'h8000, 1'b0);
    // R2: program pages while disabled, still flash page 0
    ioWrite(8'h78, 8'hC5, 1'b1, 1'b1);
    ioWrite(8'h79, 8'h21, 1'b1, 1'b1);
    ioWrite(8'h7A, 8'h3F, 1'b1, 1'b1);
    ioWrite(8'h7B, 8'h0E, 1'b1, 1'b1);
    sweep("R2");
    // R4: enable with upper bits set, bit0 decides
    ioWrite(8'h7C, 8'hFE, 1'b1, 1'b1);
    sweep("R4");
    ioWrite(8'h7C, 8'h81, 1'b1, 1'b1);
    // R3 R6 R7 mapping, bits 7:6 dropped
    sweep("R3 R6 R7");
    check("R6 bank3 top", 16'hFFFF, 1'b1);
    check("R6 bank0 base", 16'h0000, 1'b1);
    // R5 rejected cycles
    ioWrite(8'h79, 8'h05, 1'b0, 1'b1);
    ioWrite(8'h7A, 8'h05, 1'b1, 1'b0);
    ioWrite(8'h74, 8'h05, 1'b1, 1'b1);
    ioWrite(8'h7D, 8'h00, 1'b1, 1'b1);
    sweep("R5");
    // R8 disable then re-enable keeps pages
    ioWrite(8'h7C, 8'h00, 1'b1, 1'b1);
    sweep("R8 off");
    ioWrite(8'h7C, 8'h01, 1'b1, 1'b1);
    sweep("R8 on");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] port;
      if ($urandom_range(0, 1) == 0) begin
        port = 8'h78 + 8'($urandom_range(0, 5));
        if ($urandom_range(0, 7) == 0) port = 8'($urandom);
        ioWrite(port, 8'($urandom), $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0);
      end else begin
        check("R6 R7 random", 16'($urandom), $urandom_range(0, 3) != 0);
      end
    end
    // reset again returns to R1 state
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int b = 0; b < 4; b++) expPage[b] = '0;
    expOn = 1'b0;
    ioWrite(8'h7C, 8'h01, 1'b1, 1'b1);
    sweep("R1 after reset");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule